// File: doc/BRIEF.md
# Chained Scan Debug Access Decoder

This block watches the update events of a two-device boundary-scan chain and turns the scans aimed at an on-chip debug port into transactions. The chain holds a 4-bit debug TAP next to TDI and a 6-bit second TAP behind it. Each IR update loads both instruction registers from one scan. A DR update is decoded only while the second TAP holds its all-ones bypass instruction, because only then does the debug TAP see a predictable payload. The block drops the single bypass bit and classifies the rest by the debug TAP's instruction as an abort write, a debug-port register access or an access-port register access.

The block also keeps the access-port number and register bank that were last loaded through the debug port's select register, so that an access-port transaction comes out with a full 8-bit register address and the port it targets. A bus engine behind the block carries out the transactions. That engine also returns read data, which this block does not handle.

Top module: `scan_dap_decoder`

## Requirements
- R1: After reset `txn_valid` is 0, both instruction registers are all ones (so a DR update produces no transaction), and the stored access-port number and bank are zero.
- R2: On `ir_upd`, `scan_bits[5:0]` load the second TAP's instruction and `scan_bits[9:6]` load the debug TAP's instruction.
- R3: A DR update produces no transaction unless the second TAP's instruction is 6'h3F.
- R4: The payload of a decoded DR update is `scan_bits` without bit 0. The value of bit 0 has no effect on any output.
- R5: Debug instruction 4'h8 gives an abort, 4'hA a debug-port access and 4'hB an access-port access. Any other value gives no transaction. `txn_kind` reports 2'b01 for abort, 2'b10 for debug-port access and 2'b11 for access-port access.
- R6: An abort reports payload bits 31:0 as data, with `txn_rd` 0 and `txn_addr` 0.
- R7: For port accesses, payload bit 0 is the direction (1 = read) and payload bits 34:3 are the data.
- R8: A debug-port access reports `txn_addr` = payload bits 2:1 times four, zero extended to 8 bits.
- R9: A debug-port access to address 8'h08, read or write, stores data bits 31:24 as the access-port number and data bits 7:4 as the bank. The change applies from the next transaction; the select transaction itself reports the previous port number.
- R10: An access-port access reports `txn_addr` = {bank, payload bits 2:1, 2'b00} and `txn_apsel` = the stored port number.
- R11: Each decoded DR update raises `txn_valid` for exactly the cycle after the strobe, and back-to-back strobes give back-to-back transactions. A DR update on the same cycle as an IR update is decoded with the instructions held before that IR update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_upd | input | 1 | IR update strobe for the whole chain |
| dr_upd | input | 1 | DR update strobe for the whole chain |
| scan_bits | input | 36 | Bits shifted in, first bit in bit 0 |
| txn_valid | output | 1 | One-cycle transaction strobe |
| txn_kind | output | 2 | 01 abort, 10 debug-port, 11 access-port |
| txn_rd | output | 1 | 1 = read, 0 = write |
| txn_data | output | 32 | Transaction data |
| txn_addr | output | 8 | Register address |
| txn_apsel | output | 8 | Access-port number |

## Verification
The hardest case to reach is the ordering around the select register. The select transaction must still report the old port number, and only the access-port access after it may use the new number and bank. A select issued as a read must take effect in the same way. The stimulus writes select, issues an access-port access, then loads select again through a read and accesses again. It also fires an IR update and a DR update on the same cycle, with an IR value that leaves bypass, which shows that the DR is decoded with the old instructions.

// File: rtl/scan_dap_pkg.sv
package scan_dap_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_ABORT = 2'b01,
    KIND_DP    = 2'b10,
    KIND_AP    = 2'b11
  } txn_kind_e;
endpackage

// File: rtl/scan_ir_tracker.sv
module scan_ir_tracker #(
  parameter int DBG_W = 4,
  parameter int BYP_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ir_upd,
  input  logic [DBG_W+BYP_W-1:0] ir_bits,
  output logic [DBG_W-1:0]       dbg_ir,
  output logic [BYP_W-1:0]       byp_ir,
  output logic                   bypassed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_ir <= '1;
      byp_ir <= '1;
    end else if (ir_upd) begin
      byp_ir <= ir_bits[BYP_W-1:0];
      dbg_ir <= ir_bits[DBG_W+BYP_W-1:BYP_W];
    end
  end

  assign bypassed = &byp_ir;
endmodule

// File: rtl/scan_sel_state.sv
module scan_sel_state #(
  parameter int DATA_W  = 32,
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4,
  parameter int BANK_LO = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_wr,
  input  logic [DATA_W-1:0]  sel_data,
  output logic [APSEL_W-1:0] apsel,
  output logic [BANK_W-1:0]  bank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      apsel <= '0;
      bank  <= '0;
    end else if (sel_wr) begin
      apsel <= sel_data[DATA_W-1 -: APSEL_W];
      bank  <= sel_data[BANK_LO +: BANK_W];
    end
  end
endmodule

// File: rtl/scan_txn_decode.sv
module scan_txn_decode
  import scan_dap_pkg::*;
#(
  parameter int             DATA_W  = 32,
  parameter int             DBG_W   = 4,
  parameter int             APSEL_W = 8,
  parameter int             BANK_W  = 4,
  parameter logic [DBG_W-1:0] OP_ABORT = 4'h8,
  parameter logic [DBG_W-1:0] OP_DP    = 4'hA,
  parameter logic [DBG_W-1:0] OP_AP    = 4'hB,
  parameter logic [1:0]     SEL_OFS = 2'b10,
  localparam int            PAY_W   = DATA_W + 3,
  localparam int            ADDR_W  = BANK_W + 4
) (
  input  logic               dr_upd,
  input  logic [PAY_W-1:0]   payload,
  input  logic [DBG_W-1:0]   dbg_ir,
  input  logic               bypassed,
  input  logic [BANK_W-1:0]  bank,
  output logic               hit,
  output txn_kind_e          kind,
  output logic               rd,
  output logic [DATA_W-1:0]  data,
  output logic [ADDR_W-1:0]  addr,
  output logic               sel_wr
);
  logic [1:0] ofs;
  assign ofs = payload[2:1];

  always_comb begin
    hit    = 1'b0;
    kind   = KIND_NONE;
    rd     = 1'b0;
    data   = payload[DATA_W+2:3];
    addr   = '0;
    sel_wr = 1'b0;
    if (dr_upd && bypassed) begin
      if (dbg_ir == OP_ABORT) begin
        hit  = 1'b1;
        kind = KIND_ABORT;
        data = payload[DATA_W-1:0];
      end else if (dbg_ir == OP_DP) begin
        hit    = 1'b1;
        kind   = KIND_DP;
        rd     = payload[0];
        addr   = {{BANK_W{1'b0}}, ofs, 2'b00};
        sel_wr = (ofs == SEL_OFS);
      end else if (dbg_ir == OP_AP) begin
        hit  = 1'b1;
        kind = KIND_AP;
        rd   = payload[0];
        addr = {bank, ofs, 2'b00};
      end
    end
  end
endmodule

// File: rtl/scan_dap_decoder.sv
module scan_dap_decoder
  import scan_dap_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DBG_W   = 4,
  parameter int BYP_W   = 6,
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4,
  localparam int SCAN_W = DATA_W + 4,
  localparam int ADDR_W = BANK_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ir_upd,
  input  logic               dr_upd,
  input  logic [SCAN_W-1:0]  scan_bits,
  output logic               txn_valid,
  output logic [1:0]         txn_kind,
  output logic               txn_rd,
  output logic [DATA_W-1:0]  txn_data,
  output logic [ADDR_W-1:0]  txn_addr,
  output logic [APSEL_W-1:0] txn_apsel
);
  logic [DBG_W-1:0]   dbg_ir;
  logic [BYP_W-1:0]   byp_ir;
  logic               bypassed;
  logic [APSEL_W-1:0] apsel;
  logic [BANK_W-1:0]  bank;
  logic               d_hit, d_rd, d_sel;
  txn_kind_e          d_kind;
  logic [DATA_W-1:0]  d_data;
  logic [ADDR_W-1:0]  d_addr;

  scan_ir_tracker #(.DBG_W(DBG_W), .BYP_W(BYP_W)) u_ir (
    .clk(clk), .rst(rst), .ir_upd(ir_upd),
    .ir_bits(scan_bits[DBG_W+BYP_W-1:0]),
    .dbg_ir(dbg_ir), .byp_ir(byp_ir), .bypassed(bypassed)
  );

  scan_txn_decode #(.DATA_W(DATA_W), .DBG_W(DBG_W), .APSEL_W(APSEL_W),
                    .BANK_W(BANK_W)) u_dec (
    .dr_upd(dr_upd), .payload(scan_bits[SCAN_W-1:1]), .dbg_ir(dbg_ir),
    .bypassed(bypassed), .bank(bank), .hit(d_hit), .kind(d_kind),
    .rd(d_rd), .data(d_data), .addr(d_addr), .sel_wr(d_sel)
  );

  scan_sel_state #(.DATA_W(DATA_W), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_sel (
    .clk(clk), .rst(rst), .sel_wr(d_sel), .sel_data(d_data),
    .apsel(apsel), .bank(bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txn_valid <= 1'b0;
      txn_kind  <= KIND_NONE;
      txn_rd    <= 1'b0;
      txn_data  <= '0;
      txn_addr  <= '0;
      txn_apsel <= '0;
    end else begin
      txn_valid <= d_hit;
      if (d_hit) begin
        txn_kind  <= d_kind;
        txn_rd    <= d_rd;
        txn_data  <= d_data;
        txn_addr  <= d_addr;
        txn_apsel <= apsel;
      end
    end
  end
endmodule

// File: rtl/scan_dap_decoder_chk.sv
module scan_dap_decoder_chk #(
  parameter int DBG_W  = 4,
  parameter int BYP_W  = 6,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dr_upd,
  input logic [DBG_W-1:0]  dbg_ir,
  input logic [BYP_W-1:0]  byp_ir,
  input logic              txn_valid,
  input logic [1:0]        txn_kind,
  input logic              txn_rd,
  input logic [ADDR_W-1:0] txn_addr
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
    txn_valid |-> $past(dr_upd)); // R11
  AST_SILENT_OFF_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (dr_upd && byp_ir != '1) |=> !txn_valid); // R3
  AST_SILENT_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    (dr_upd && dbg_ir != 4'h8 && dbg_ir != 4'hA && dbg_ir != 4'hB) |=> !txn_valid); // R5
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> txn_kind != 2'b00); // R5
  AST_ABORT_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_kind == 2'b01) |-> (!txn_rd && txn_addr == '0)); // R6
  AST_DP_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_kind == 2'b10) |-> (txn_addr[1:0] == 2'b00 && txn_addr[ADDR_W-1:4] == '0)); // R8
endmodule

bind scan_dap_decoder scan_dap_decoder_chk #(.DBG_W(DBG_W), .BYP_W(BYP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dr_upd(dr_upd), .dbg_ir(dbg_ir), .byp_ir(byp_ir),
  .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_rd(txn_rd), .txn_addr(txn_addr)
);

// File: tb/scan_dap_decoder_bench.sv
module scan_dap_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_upd = 1'b0, dr_upd = 1'b0;
  logic [35:0] scan_bits = '0;
  logic        txn_valid, txn_rd;
  logic [1:0]  txn_kind;
  logic [31:0] txn_data;
  logic [7:0]  txn_addr, txn_apsel;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_dap_decoder u_scan_dap_decoder (
    .clk(clk), .rst(rst), .ir_upd(ir_upd), .dr_upd(dr_upd),
    .scan_bits(scan_bits), .txn_valid(txn_valid), .txn_kind(txn_kind),
    .txn_rd(txn_rd), .txn_data(txn_data), .txn_addr(txn_addr),
    .txn_apsel(txn_apsel)
  );

  function automatic logic [35:0] acc(input logic [31:0] d, input logic [1:0] ofs,
                                      input logic rd, input logic bb);
    return {d, ofs, rd, bb};
  endfunction

  task automatic expect_none(input string tag);
    n_tests++;
    if (txn_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: txn_valid=%b expected 0", tag, txn_valid);
    end
  endtask

  task automatic expect_txn(input string tag, input logic [1:0] k, input logic rd,
                            input logic [31:0] d, input logic [7:0] a, input logic [7:0] ap);
    n_tests++;
    if (txn_valid !== 1'b1 || txn_kind !== k || txn_rd !== rd || txn_data !== d ||
        txn_addr !== a || txn_apsel !== ap) begin
      n_fail++;
      $display("FAIL %s: got v=%b k=%b rd=%b d=%h a=%h ap=%h expected v=1 k=%b rd=%b d=%h a=%h ap=%h",
               tag, txn_valid, txn_kind, txn_rd, txn_data, txn_addr, txn_apsel, k, rd, d, a, ap);
    end
  endtask

  // one strobe cycle; returns at the negedge where the registered result is visible
  task automatic strobe(input logic i, input logic d, input logic [35:0] s);
    @(negedge clk);
    ir_upd = i; dr_upd = d; scan_bits = s;
    @(negedge clk);
    ir_upd = 1'b0; dr_upd = 1'b0;
  endtask

  task automatic set_ir(input logic [3:0] dbg, input logic [5:0] byp);
    strobe(1'b1, 1'b0, {26'd0, dbg, byp});
  endtask

  task automatic t_reset();
    expect_none("R1 reset valid");
    strobe(1'b0, 1'b1, acc(32'h1234_5678, 2'b01, 1'b0, 1'b0));
    expect_none("R1 instructions all ones after reset");
    set_ir(4'hB, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'hCAFE_0001, 2'b11, 1'b1, 1'b0));
    expect_txn("R1 bank and port zero after reset", 2'b11, 1'b1, 32'hCAFE_0001, 8'h0C, 8'h00);
  endtask

  task automatic t_ir_split();
    set_ir(4'hA, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h0000_00A5, 2'b01, 1'b1, 1'b0));
    expect_txn("R2 debug IR from bits 9:6", 2'b10, 1'b1, 32'h0000_00A5, 8'h04, 8'h00);
    set_ir(4'hA, 6'h3E);
    strobe(1'b0, 1'b1, acc(32'h0000_00A5, 2'b01, 1'b1, 1'b0));
    expect_none("R3 second TAP not in bypass");
    set_ir(4'hA, 6'h1F);
    strobe(1'b0, 1'b1, acc(32'h0000_00A5, 2'b01, 1'b1, 1'b0));
    expect_none("R3 second TAP top bit clear");
  endtask

  task automatic t_abort();
    logic [35:0] s;
    set_ir(4'h8, 6'h3F);
    s = {3'b101, 32'hDEAD_BEEF, 1'b1};
    strobe(1'b0, 1'b1, s);
    expect_txn("R6 abort low 32 payload bits", 2'b01, 1'b0, 32'hDEAD_BEEF, 8'h00, 8'h00);
    s[0] = 1'b0;
    strobe(1'b0, 1'b1, s);
    expect_txn("R4 bypass bit ignored on abort", 2'b01, 1'b0, 32'hDEAD_BEEF, 8'h00, 8'h00);
  endtask

  task automatic t_dp();
    set_ir(4'hA, 6'h3F);
    for (int o = 0; o < 4; o++) begin
      if (o == 2) continue;
      strobe(1'b0, 1'b1, acc(32'h1111_0000 + o, o[1:0], o[0], 1'b1));
      expect_txn($sformatf("R8 R7 dp offset %0d", o), 2'b10, o[0],
                 32'h1111_0000 + o, {4'h0, o[1:0], 2'b00}, 8'h00);
    end
    strobe(1'b0, 1'b1, acc(32'h8765_4321, 2'b11, 1'b0, 1'b0));
    expect_txn("R4 bypass bit zero on dp write", 2'b10, 1'b0, 32'h8765_4321, 8'h0C, 8'h00);
  endtask

  task automatic t_select();
    set_ir(4'hA, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h0500_0030, 2'b10, 1'b0, 1'b0));
    expect_txn("R9 select reports old port", 2'b10, 1'b0, 32'h0500_0030, 8'h08, 8'h00);
    set_ir(4'hB, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h0000_0042, 2'b11, 1'b0, 1'b1));
    expect_txn("R10 ap address uses bank", 2'b11, 1'b0, 32'h0000_0042, 8'h3C, 8'h05);
    set_ir(4'hA, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h0200_00F0 | 32'h0000_0070, 2'b10, 1'b1, 1'b0));
    expect_txn("R9 select read", 2'b10, 1'b1, 32'h0200_00F0, 8'h08, 8'h05);
    set_ir(4'hB, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h0000_0007, 2'b01, 1'b1, 1'b0));
    expect_txn("R9 R10 select by read applied", 2'b11, 1'b1, 32'h0000_0007, 8'hF4, 8'h02);
  endtask

  task automatic t_unknown();
    set_ir(4'hC, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h1, 2'b00, 1'b0, 1'b0));
    expect_none("R5 unknown debug op 0xC");
    set_ir(4'h9, 6'h3F);
    strobe(1'b0, 1'b1, acc(32'h1, 2'b00, 1'b0, 1'b0));
    expect_none("R5 unknown debug op 0x9");
  endtask

  task automatic t_timing();
    logic [35:0] s;
    set_ir(4'hA, 6'h3F);
    // low 10 bits = {4'hA, 6'h3E}: leaves bypass, but this DR uses old IR
    s = {26'h2A5_5A5A, 4'hA, 6'h3E};
    strobe(1'b1, 1'b1, s);
    expect_txn("R11 same-cycle IR and DR", 2'b10, s[1], s[35:4], {4'h0, s[3:2], 2'b00}, 8'h02);
    @(negedge clk);
    expect_none("R11 valid lasts one cycle");
    strobe(1'b0, 1'b1, acc(32'h1, 2'b00, 1'b0, 1'b0));
    expect_none("R3 bypass left by same-cycle IR");
    set_ir(4'hA, 6'h3F);
    @(negedge clk);
    dr_upd = 1'b1; scan_bits = acc(32'hAAAA_0001, 2'b00, 1'b1, 1'b0);
    @(negedge clk);
    expect_txn("R11 back-to-back first", 2'b10, 1'b1, 32'hAAAA_0001, 8'h00, 8'h02);
    scan_bits = acc(32'hBBBB_0002, 2'b11, 1'b0, 1'b1);
    @(negedge clk);
    dr_upd = 1'b0;
    expect_txn("R11 back-to-back second", 2'b10, 1'b0, 32'hBBBB_0002, 8'h0C, 8'h02);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ir_split();
    t_abort();
    t_dp();
    t_select();
    t_unknown();
    t_timing();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule